// File: doc/BRIEF.md
# Pointer-Packet Value Reuse Buffer

This block sits on the consuming side of a one-way communication stream. Each packet in the stream is either a data packet, which carries a real value, or a pointer packet, which names a slot in a small local store of values that the consumer has itself computed recently. The supplier sends a pointer packet when the value it owes the consumer is one the consumer will compute. The supplier can then keep running ahead instead of waiting for that value to come back.

The compute datapath writes every new result into the local store through a write port. Slots are taken in round-robin order, and the port reports which slot the next write will use so that the compute side can tell the supplier the index. The consume port takes the packet at the head of the stream when a consume request is present. It returns the payload of a data packet, or the stored value for a pointer packet. A pointer to a slot that has never been written holds the stream until that slot is written. A write that lands on the named slot in the same cycle is forwarded straight to the response.

Top module: `ptr_reuse_buf`

## Requirements
- R1: After reset, resp_valid is 0, wr_idx is 0 and every slot is empty, so a pointer packet to any slot is not accepted.
- R2: A data packet (type flag pkt_is_ptr = 0) is accepted in a cycle where pkt_valid and cons_req are both 1. In the next cycle resp_valid is 1 and resp_data equals that packet's payload.
- R3: A pointer packet (pkt_is_ptr = 1) that names a written slot is accepted like a data packet. Its response, one cycle later, is the last value written to that slot.
- R4: Each write (wr_en = 1) stores wr_data in the slot shown on wr_idx during that cycle. wr_idx then advances by one and wraps from SLOTS-1 to 0. Without a write, wr_idx holds its value.
- R5: A pointer packet that names a slot never written since reset, with no write to that slot in the same cycle, keeps pkt_ready at 0 and produces no response until that slot is written.
- R6: When a pointer packet is accepted in the same cycle that the write port fills the slot it names, the response carries the value being written.
- R7: A slot that has been overwritten returns its newest value to later pointer packets.
- R8: pkt_ready is 1 only when both pkt_valid and cons_req are 1. resp_valid is 1 only in the cycle after a packet is accepted.
- R9: A pointer packet names its slot through payload bits [IDX_W-1:0]. The upper payload bits have no effect on which slot is read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Store wr_data in the next round-robin slot |
| wr_data | input | DATA_W | Newly computed value |
| wr_idx | output | IDX_W | Slot that a write in this cycle uses |
| pkt_valid | input | 1 | A packet is present at the stream head |
| pkt_is_ptr | input | 1 | Packet type: 0 data, 1 pointer |
| pkt_payload | input | DATA_W | Data word, or slot index in the low bits |
| pkt_ready | output | 1 | Head packet is consumed this cycle |
| cons_req | input | 1 | Consumer asks for the next value |
| resp_valid | output | 1 | Response word is present |
| resp_data | output | DATA_W | Resolved value of the consumed packet |

## Verification
pkt_ready and wr_idx are combinational from the present inputs and the stored state. The bench checks them one nanosecond after it drives the inputs on the falling edge, before the rising edge that commits the cycle. resp_valid and resp_data come from a register one edge later, so they are checked one nanosecond after the next rising edge against the value that the reference model predicted for that cycle. The slot contents change at that same edge, and the model updates them there, after it has recorded the prediction. This lets a same-cycle write and pointer read be told apart from a read of the old slot content.

// File: rtl/reuse_pkg.sv
package reuse_pkg;

  typedef enum logic {
    PKT_DATA = 1'b0,
    PKT_PTR  = 1'b1
  } pkt_kind_e;

  // round-robin successor of a slot number among n slots
  function automatic int unsigned wrap_next(input int unsigned idx, input int unsigned n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

  // a consumed packet can resolve if it is data, its slot holds a value,
  // or the slot is being filled right now
  function automatic logic can_resolve(input logic is_ptr, input logic slot_full,
                                       input logic slot_filling);
    return !is_ptr || slot_full || slot_filling;
  endfunction

endpackage

// File: rtl/slot_alloc.sv
module slot_alloc #(
  parameter int unsigned SLOTS = 16,
  localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  output logic [IDX_W-1:0] cur_idx
);
  import reuse_pkg::*;

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (wr_en) idx_q <= IDX_W'(wrap_next(int'(idx_q), SLOTS));
  end

  assign cur_idx = idx_q;
endmodule

// File: rtl/value_store.sv
module value_store #(
  parameter int unsigned SLOTS  = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_full,
  output logic              rd_filling
);
  logic [DATA_W-1:0] slot_val [SLOTS];
  logic [SLOTS-1:0]  slot_full;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(s));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_val[s]  <= '0;
        slot_full[s] <= 1'b0;
      end else if (hit) begin
        slot_val[s]  <= wr_data;
        slot_full[s] <= 1'b1;
      end
    end
  end

  logic in_range;
  assign in_range   = (32'(rd_idx) < SLOTS);
  assign rd_filling = wr_en && (wr_idx == rd_idx);
  assign rd_full    = in_range && slot_full[rd_idx];

  always_comb begin
    if (rd_filling)    rd_data = wr_data;
    else if (in_range) rd_data = slot_val[rd_idx];
    else               rd_data = '0;
  end
endmodule

// File: rtl/consume_ctl.sv
module consume_ctl #(
  parameter int unsigned SLOTS  = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  input  logic              pkt_is_ptr,
  input  logic [DATA_W-1:0] pkt_payload,
  input  logic              cons_req,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              rd_full,
  input  logic              rd_filling,
  output logic              take,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data
);
  import reuse_pkg::*;

  logic [DATA_W-1:0] resolved;

  assign rd_idx   = pkt_payload[IDX_W-1:0];
  assign take     = pkt_valid && cons_req && can_resolve(pkt_is_ptr, rd_full, rd_filling);
  assign resolved = (pkt_kind_e'(pkt_is_ptr) == PKT_PTR) ? rd_data : pkt_payload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resp_valid <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= take;
      if (take) resp_data <= resolved;
    end
  end
endmodule

// File: rtl/ptr_reuse_buf.sv
module ptr_reuse_buf #(
  parameter int unsigned SLOTS  = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [IDX_W-1:0]  wr_idx,
  input  logic              pkt_valid,
  input  logic              pkt_is_ptr,
  input  logic [DATA_W-1:0] pkt_payload,
  output logic              pkt_ready,
  input  logic              cons_req,
  output logic              resp_valid,
  output logic [DATA_W-1:0] resp_data
);
  logic [IDX_W-1:0]  rd_idx;
  logic [DATA_W-1:0] rd_data;
  logic              rd_full;
  logic              rd_filling;
  logic              take;

  slot_alloc #(.SLOTS(SLOTS)) u_alloc (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cur_idx(wr_idx)
  );

  value_store #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_data(rd_data), .rd_full(rd_full), .rd_filling(rd_filling)
  );

  consume_ctl #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_is_ptr(pkt_is_ptr),
    .pkt_payload(pkt_payload), .cons_req(cons_req), .rd_idx(rd_idx),
    .rd_data(rd_data), .rd_full(rd_full), .rd_filling(rd_filling),
    .take(take), .resp_valid(resp_valid), .resp_data(resp_data)
  );

  assign pkt_ready = take;
endmodule

// File: rtl/ptr_reuse_buf_chk.sv
module ptr_reuse_buf_chk #(
  parameter int unsigned SLOTS  = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [IDX_W-1:0]  wr_idx,
  input logic              pkt_valid,
  input logic              pkt_is_ptr,
  input logic [DATA_W-1:0] pkt_payload,
  input logic              pkt_ready,
  input logic              cons_req,
  input logic              resp_valid,
  input logic [DATA_W-1:0] resp_data,
  input logic              slot_full
);
  import reuse_pkg::*;

  logic same_slot;
  assign same_slot = wr_en && (wr_idx == pkt_payload[IDX_W-1:0]);

  AST_READY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |-> (pkt_valid && cons_req)); // R8

  AST_RESP_AFTER_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_ready |=> resp_valid); // R2

  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_ready |=> !resp_valid); // R8

  AST_DATA_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_ready && !pkt_is_ptr) |=> (resp_data == $past(pkt_payload))); // R2

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (32'(wr_idx) == wrap_next(32'($past(wr_idx)), SLOTS))); // R4

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(wr_idx)); // R4

  AST_EMPTY_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && pkt_is_ptr && !slot_full && !same_slot) |-> !pkt_ready); // R5

  AST_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_ready && pkt_is_ptr && same_slot) |=> (resp_data == $past(wr_data))); // R6
endmodule

bind ptr_reuse_buf ptr_reuse_buf_chk #(.SLOTS(SLOTS), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_idx(wr_idx),
  .pkt_valid(pkt_valid), .pkt_is_ptr(pkt_is_ptr), .pkt_payload(pkt_payload),
  .pkt_ready(pkt_ready), .cons_req(cons_req), .resp_valid(resp_valid),
  .resp_data(resp_data), .slot_full(rd_full)
);

// File: tb/ptr_reuse_buf_tb.sv
`timescale 1ns/1ps
module ptr_reuse_buf_tb;
  localparam int SLOTS = 16;
  localparam int DW    = 32;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          wr_en = 0;
  logic [DW-1:0] wr_data = '0;
  logic [3:0]    wr_idx;
  logic          pkt_valid = 0, pkt_is_ptr = 0, cons_req = 0;
  logic [DW-1:0] pkt_payload = '0;
  logic          pkt_ready, resp_valid;
  logic [DW-1:0] resp_data;

  always #4 clk = ~clk;

  ptr_reuse_buf u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_idx(wr_idx),
    .pkt_valid(pkt_valid), .pkt_is_ptr(pkt_is_ptr), .pkt_payload(pkt_payload),
    .pkt_ready(pkt_ready), .cons_req(cons_req), .resp_valid(resp_valid),
    .resp_data(resp_data)
  );

  int checks = 0, errors = 0;
  logic [DW-1:0] m_val [SLOTS];
  bit            m_full [SLOTS];
  int            m_wp = 0;

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input bit w, input logic [DW-1:0] wd, input bit pv,
                      input bit ptr, input logic [DW-1:0] pl, input bit rq,
                      input string req);
    int  slot;
    bit  fwd, e_take;
    logic [DW-1:0] e_val;
    @(negedge clk);
    wr_en = w; wr_data = wd; pkt_valid = pv; pkt_is_ptr = ptr;
    pkt_payload = pl; cons_req = rq;
    #1;
    slot   = int'(pl % SLOTS);
    fwd    = w && (m_wp == slot);
    e_take = pv && rq && (!ptr || m_full[slot] || fwd);
    e_val  = !ptr ? pl : (fwd ? wd : m_val[slot]);
    chk(pkt_ready == e_take, {req, " ready"}, DW'(pkt_ready), DW'(e_take));
    chk(int'(wr_idx) == m_wp, "R4 wr_idx", DW'(wr_idx), DW'(m_wp));
    if (w) begin
      m_val[m_wp] = wd; m_full[m_wp] = 1; m_wp = (m_wp + 1) % SLOTS;
    end
    @(posedge clk); #1;
    chk(resp_valid == e_take, {req, " resp_valid"}, DW'(resp_valid), DW'(e_take));
    if (e_take) chk(resp_data == e_val, {req, " resp_data"}, resp_data, e_val);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < SLOTS; i++) begin m_val[i] = '0; m_full[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    chk(resp_valid == 0, "R1 reset resp_valid", DW'(resp_valid), 0);
    chk(wr_idx == 0, "R1 reset wr_idx", DW'(wr_idx), 0);
    rst_n = 1;
    // R1: empty after reset, pointer stalls
    step(0, 0, 1, 1, 32'd3, 1, "R1");
    step(0, 0, 1, 1, 32'd0, 1, "R1");
    // R2: data packets
    step(0, 0, 1, 0, 32'hDEAD_BEEF, 1, "R2");
    step(0, 0, 1, 0, 32'h0000_0000, 1, "R2");
    step(0, 0, 1, 0, 32'hFFFF_FFFF, 1, "R2");
    // R4: fill slots 0..4
    for (int i = 0; i < 5; i++) step(1, 32'h100 + i, 0, 0, 0, 0, "R4");
    // R3: pointer reads
    step(0, 0, 1, 1, 32'd2, 1, "R3");
    step(0, 0, 1, 1, 32'd0, 1, "R3");
    step(0, 0, 1, 1, 32'd4, 1, "R3");
    // R8: no request, no packet
    step(0, 0, 1, 0, 32'h55, 0, "R8");
    step(0, 0, 0, 0, 32'h66, 1, "R8");
    step(0, 0, 1, 1, 32'd1, 0, "R8");
    // R5: pointer to slot 7 held while slots 5,6 fill
    step(0, 0, 1, 1, 32'd7, 1, "R5");
    step(1, 32'hA5, 1, 1, 32'd7, 1, "R5");
    step(1, 32'hA6, 1, 1, 32'd7, 1, "R5");
    // R6: slot 7 written in the same cycle as the read
    step(1, 32'hA7, 1, 1, 32'd7, 1, "R6");
    step(0, 0, 1, 1, 32'd7, 1, "R3");
    // R9: upper payload bits ignored
    step(0, 0, 1, 1, 32'hABCD_0002, 1, "R9");
    step(0, 0, 1, 1, 32'hFFFF_FFF6, 1, "R9");
    // R4 wrap and R7 overwrite
    for (int i = 0; i < 10; i++) step(1, 32'h200 + i, 0, 0, 0, 0, "R4");
    step(0, 0, 1, 1, 32'd0, 1, "R7");
    step(0, 0, 1, 1, 32'd1, 1, "R7");
    step(0, 0, 1, 1, 32'd10, 1, "R7");
    // R6 with data and write mixed, write while data consumed
    step(1, 32'h300, 1, 0, 32'h77, 1, "R2");
    step(1, 32'h301, 1, 1, 32'd3, 1, "R6");
    step(0, 0, 0, 0, 0, 0, "R8");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule